// File: doc/BRIEF.md
# Effective Address and Operand Unit

This unit resolves the source operand of a two-word load instruction. The first word carries the opcode and a 4-bit addressing-mode field. The second word, stored one location above the instruction, holds either an address or a constant. When `start` is pulsed, the unit captures the instruction location, the mode and the current values of the general register R1 and the index register XR. It then reads memory through a request/acknowledge port as the mode requires. It returns the effective address, the operand for the accumulator and the value R1 must take afterwards. `done` is raised for one cycle when the results are valid.

The control is a five-state machine. The states are `S_IDLE`, `S_FETCH_AW` (read the address word), `S_FETCH_PTR` (read the pointer for indirect mode), `S_FETCH_OPND` (read the operand) and `S_DONE`. The transitions are:
- `S_IDLE` goes to `S_DONE` on `start` for register mode or for an unused code.
- `S_IDLE` goes to `S_FETCH_AW` for the five modes that use the address word.
- `S_IDLE` goes to `S_FETCH_OPND` for the three modes that take R1 as a pointer.
- `S_FETCH_AW` goes on acknowledge to `S_DONE` (immediate), to `S_FETCH_PTR` (indirect) or to `S_FETCH_OPND` (all other modes).
- `S_FETCH_PTR` goes to `S_FETCH_OPND` on acknowledge.
- `S_FETCH_OPND` goes to `S_DONE` on acknowledge.
- `S_DONE` always returns to `S_IDLE`.

All address arithmetic wraps modulo 2^AW. Mode codes: 0 direct, 1 immediate, 2 indirect, 3 relative, 4 indexed, 5 register, 6 register-indirect, 7 autoincrement, 8 autodecrement. Codes 9 to 15 are unused.

Top module: `ea_operand_unit`

## Requirements
- R1: During and right after reset, `done`, `mem_req`, `mode_err`, `ea`, `operand` and `r1_out` are all 0.
- R2: For modes 0 to 4, the first memory read uses address `instr_loc + 1`, and the word returned is the address word (AW).
- R3: Immediate mode (code 1) gives `ea = instr_loc + 1` and `operand = AW`, with exactly one memory read.
- R4: Direct mode (code 0) gives `ea = AW` and `operand = M[AW]`, with two reads.
- R5: Indirect mode (code 2) gives `ea = M[AW]` and `operand = M[ea]`, with three reads.
- R6: Relative mode (code 3) gives `ea = instr_loc + 2 + AW`, wrapping modulo 2^AW, and `operand = M[ea]`, with two reads.
- R7: Indexed mode (code 4) gives `ea = XR + AW`, wrapping, and `operand = M[ea]`, with two reads.
- R8: Register mode (code 5) gives `operand = R1` (zero-extended) and `ea = 0`. It makes no memory read, and `done` rises one cycle after `start`.
- R9: Register-indirect mode (code 6) gives `ea = R1` and `operand = M[R1]`, with one read, and `r1_out = R1`.
- R10: Autoincrement mode (code 7) gives `ea = R1` and `operand = M[R1]`, and `r1_out = R1 + 1` (wrapping). `r1_out` changes only in the cycle where `done` is high.
- R11: Autodecrement mode (code 8) gives `ea = R1 - 1` and `operand = M[R1 - 1]`, and `r1_out = R1 - 1` (wrapping).
- R12: Codes 9 to 15 raise `mode_err` together with `done` one cycle after `start`. No memory read is made, `ea = 0`, `operand = 0` and `r1_out = R1`. In every valid mode `mode_err` is 0.
- R13: `done` lasts exactly one cycle. A pending request keeps `mem_req` high and `mem_addr` stable until `mem_ack`. A `start` pulse, or a change of inputs, while an operation is in progress has no effect on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving one instruction (sampled in idle only) |
| instr_loc | input | AW | Location of the instruction's first word |
| mode | input | 4 | Addressing-mode code |
| r1_in | input | AW | Current general register R1 |
| xr_in | input | AW | Current index register XR |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | Read data valid, request accepted |
| mem_rdata | input | DW | Memory read data |
| ea | output | AW | Effective address |
| operand | output | DW | Operand for the accumulator |
| r1_out | output | AW | R1 value after the instruction |
| mode_err | output | 1 | Unused mode code seen |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Assertions check the following on every cycle:
- `done` stays a single-cycle pulse.
- A pending request holds both `mem_req` and `mem_addr` steady until acknowledged.
- Register mode and unused codes reach `S_DONE` in one cycle.
- `r1_out` moves only together with `done`.

The address arithmetic of each mode, the wrap at the top of the address space, the number and order of memory reads and the immunity to a second `start` during a run can only be shown by the bench scenarios. The bench uses a computed memory image and varied acknowledge latencies for these.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        AM_DIRECT  = 4'd0,
        AM_IMMED   = 4'd1,
        AM_INDIR   = 4'd2,
        AM_REL     = 4'd3,
        AM_INDEX   = 4'd4,
        AM_REG     = 4'd5,
        AM_REGIND  = 4'd6,
        AM_AUTOINC = 4'd7,
        AM_AUTODEC = 4'd8
    } am_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_AW,
        S_FETCH_PTR,
        S_FETCH_OPND,
        S_DONE
    } ea_state_e;

    localparam logic [3:0] AM_LAST = 4'd8;

    function automatic logic am_valid(input logic [3:0] m);
        return m <= AM_LAST;
    endfunction

    // modes that fetch the second instruction word
    function automatic logic am_needs_aw(input logic [3:0] m);
        return m <= 4'd4;
    endfunction

    // modes that use R1 as the memory pointer
    function automatic logic am_r1_ptr(input logic [3:0] m);
        return (m >= 4'd6) && (m <= AM_LAST);
    endfunction

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] loc,
    input  logic [AW-1:0] aw,
    input  logic [AW-1:0] xr,
    input  logic [AW-1:0] r1,
    output logic [AW-1:0] ea_aw,
    output logic [AW-1:0] ea_r1,
    output logic [AW-1:0] r1_next
);

    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] r1_inc;
    logic [AW-1:0] r1_dec;

    assign r1_inc = r1 + ONE;
    assign r1_dec = r1 - ONE;

    always_comb begin
        case (mode)
            AM_IMMED: ea_aw = loc + ONE;
            AM_REL:   ea_aw = loc + TWO + aw;
            AM_INDEX: ea_aw = xr + aw;
            default:  ea_aw = aw;
        endcase
    end

    always_comb begin
        ea_r1   = (mode == AM_AUTODEC) ? r1_dec : r1;
        case (mode)
            AM_AUTOINC: r1_next = r1_inc;
            AM_AUTODEC: r1_next = r1_dec;
            default:    r1_next = r1;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] mode,
    input  logic       mem_ack,
    output ea_state_e  state,
    output logic       capture,
    output logic       finish,
    output logic       mem_req,
    output logic       aw_ack,
    output logic       ptr_ack,
    output logic       opnd_ack,
    output logic       done
);

    ea_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!am_valid(mode) || mode == AM_REG) nxt = S_DONE;
                    else if (am_needs_aw(mode))            nxt = S_FETCH_AW;
                    else                                   nxt = S_FETCH_OPND;
                end
            end
            S_FETCH_AW: begin
                if (mem_ack) begin
                    if (mode == AM_IMMED)      nxt = S_DONE;
                    else if (mode == AM_INDIR) nxt = S_FETCH_PTR;
                    else                       nxt = S_FETCH_OPND;
                end
            end
            S_FETCH_PTR:  if (mem_ack) nxt = S_FETCH_OPND;
            S_FETCH_OPND: if (mem_ack) nxt = S_DONE;
            S_DONE:       nxt = S_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        capture  = 1'b0;
        mem_req  = 1'b0;
        aw_ack   = 1'b0;
        ptr_ack  = 1'b0;
        opnd_ack = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_IDLE:       capture = start;
            S_FETCH_AW:   begin mem_req = 1'b1; aw_ack   = mem_ack; end
            S_FETCH_PTR:  begin mem_req = 1'b1; ptr_ack  = mem_ack; end
            S_FETCH_OPND: begin mem_req = 1'b1; opnd_ack = mem_ack; end
            S_DONE:       done = 1'b1;
        endcase
        finish = (nxt == S_DONE) && (state != S_DONE);
    end

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    p_reg_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && mode == AM_REG) |=> (done && !mem_req));

    p_bad_code_fast_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !am_valid(mode)) |=> (done && !mem_req));

endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] instr_loc,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] r1_in,
    input  logic [AW-1:0] xr_in,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] ea,
    output logic [DW-1:0] operand,
    output logic [AW-1:0] r1_out,
    output logic          mode_err,
    output logic          done
);

    localparam logic [AW-1:0] ONE = AW'(1);

    ea_state_e     st;
    logic          capture, finish, aw_ack, ptr_ack, opnd_ack;
    logic [3:0]    mode_q;
    logic [AW-1:0] loc_q, xr_q, r1_q, aw_q, ea_q, r1o_q;
    logic [DW-1:0] opnd_q;
    logic          err_q;

    logic          in_idle;
    logic [3:0]    cur_mode;
    logic [AW-1:0] c_loc, c_xr, c_r1, rd_addr;
    logic [AW-1:0] c_ea_aw, c_ea_r1, c_r1_next;

    assign in_idle  = (st == S_IDLE);
    assign cur_mode = in_idle ? mode      : mode_q;
    assign c_loc    = in_idle ? instr_loc : loc_q;
    assign c_xr     = in_idle ? xr_in     : xr_q;
    assign c_r1     = in_idle ? r1_in     : r1_q;
    assign rd_addr  = AW'(mem_rdata);

    ea_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (cur_mode),
        .mem_ack  (mem_ack),
        .state    (st),
        .capture  (capture),
        .finish   (finish),
        .mem_req  (mem_req),
        .aw_ack   (aw_ack),
        .ptr_ack  (ptr_ack),
        .opnd_ack (opnd_ack),
        .done     (done)
    );

    ea_addr_calc #(.AW(AW)) u_calc (
        .mode    (cur_mode),
        .loc     (c_loc),
        .aw      (rd_addr),
        .xr      (c_xr),
        .r1      (c_r1),
        .ea_aw   (c_ea_aw),
        .ea_r1   (c_ea_r1),
        .r1_next (c_r1_next)
    );

    // read address per state
    always_comb begin
        unique case (st)
            S_FETCH_AW:   mem_addr = loc_q + ONE;
            S_FETCH_PTR:  mem_addr = aw_q;
            S_FETCH_OPND: mem_addr = ea_q;
            default:      mem_addr = '0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            loc_q  <= '0;
            xr_q   <= '0;
            r1_q   <= '0;
            aw_q   <= '0;
            ea_q   <= '0;
            opnd_q <= '0;
            r1o_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (capture) begin
                mode_q <= mode;
                loc_q  <= instr_loc;
                xr_q   <= xr_in;
                r1_q   <= c_r1_next;
                err_q  <= !am_valid(mode);
                ea_q   <= am_r1_ptr(mode) ? c_ea_r1 : '0;
                opnd_q <= (mode == AM_REG) ? DW'(r1_in) : '0;
            end
            if (aw_ack) begin
                aw_q <= rd_addr;
                if (mode_q != AM_INDIR) ea_q <= c_ea_aw;
                if (mode_q == AM_IMMED) opnd_q <= mem_rdata;
            end
            if (ptr_ack)  ea_q   <= rd_addr;
            if (opnd_ack) opnd_q <= mem_rdata;
            if (finish)   r1o_q  <= capture ? c_r1_next : r1_q;
        end
    end

    assign ea       = ea_q;
    assign operand  = opnd_q;
    assign r1_out   = r1o_q;
    assign mode_err = err_q;

    p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    p_r1_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r1_out) |-> done);

    p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err) |-> done);

    p_aw_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && am_needs_aw(mode)) |=> (mem_req && mem_addr == $past(instr_loc) + ONE));

endmodule

// File: tb/ea_operand_unit_tb.sv
`timescale 1ns/1ps
module ea_operand_unit_tb;

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] loc;
        logic [15:0] r1;
        logic [15:0] xr;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd1, 16'h0350, 16'h0834, 16'h0125, 2'd1},
        '{4'd2, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd2, 16'h1200, 16'h0001, 16'h0000, 2'd2},
        '{4'd3, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd3, 16'hFFF0, 16'h0834, 16'h0125, 2'd1},
        '{4'd4, 16'h0350, 16'h0834, 16'hF000, 2'd0},
        '{4'd5, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd6, 16'h0350, 16'h0834, 16'h0125, 2'd1},
        '{4'd7, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd7, 16'h0350, 16'hFFFF, 16'h0125, 2'd2},
        '{4'd8, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd8, 16'h0350, 16'h0000, 16'h0125, 2'd1},
        '{4'd9, 16'h0350, 16'h0834, 16'h0125, 2'd0},
        '{4'd15, 16'h0350, 16'h4321, 16'h0125, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_loc = '0;
    logic [3:0]  mode = '0;
    logic [15:0] r1_in = '0;
    logic [15:0] xr_in = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] ea, operand, r1_out;
    logic        mode_err, done;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [1:0]  cur_lat  = '0;
    logic [1:0]  wcnt     = '0;
    int          rd_cnt   = 0;
    logic [15:0] addr_log [16];

    always #10 clk = ~clk;

    ea_operand_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_loc(instr_loc),
        .mode(mode), .r1_in(r1_in), .xr_in(xr_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .ea(ea), .operand(operand),
        .r1_out(r1_out), .mode_err(mode_err), .done(done)
    );

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA55A;
    endfunction

    // memory model: ack after cur_lat wait cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt == cur_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_fn(mem_addr);
                wcnt      <= '0;
            end else begin
                mem_ack <= 1'b0;
                wcnt    <= wcnt + 2'd1;
            end
        end else begin
            mem_ack <= 1'b0;
            wcnt    <= '0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            addr_log[rd_cnt % 16] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R4";
            4'd1: return "R3";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5: return "R8";
            4'd6: return "R9";
            4'd7: return "R10";
            4'd8: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic model(input vec_t v, output logic [15:0] e_ea, output logic [15:0] e_op,
                         output logic [15:0] e_r1, output logic e_err, output int e_rd);
        logic [15:0] aw;
        aw    = mem_fn(v.loc + 16'd1);
        e_ea  = '0; e_op = '0; e_r1 = v.r1; e_err = 1'b0; e_rd = 0;
        case (v.mode)
            4'd0: begin e_ea = aw;                  e_op = mem_fn(e_ea); e_rd = 2; end
            4'd1: begin e_ea = v.loc + 16'd1;       e_op = aw;           e_rd = 1; end
            4'd2: begin e_ea = mem_fn(aw);          e_op = mem_fn(e_ea); e_rd = 3; end
            4'd3: begin e_ea = v.loc + 16'd2 + aw;  e_op = mem_fn(e_ea); e_rd = 2; end
            4'd4: begin e_ea = v.xr + aw;           e_op = mem_fn(e_ea); e_rd = 2; end
            4'd5: begin e_op = v.r1; end
            4'd6: begin e_ea = v.r1; e_op = mem_fn(e_ea); e_rd = 1; end
            4'd7: begin e_ea = v.r1; e_op = mem_fn(e_ea); e_rd = 1; e_r1 = v.r1 + 16'd1; end
            4'd8: begin e_ea = v.r1 - 16'd1; e_op = mem_fn(e_ea); e_rd = 1; e_r1 = e_ea; end
            default: e_err = 1'b1;
        endcase
    endtask

    task automatic run_vec(input vec_t v, input logic poke);
        logic [15:0] e_ea, e_op, e_r1;
        logic        e_err;
        int          e_rd, base, waited;
        string       tg;
        model(v, e_ea, e_op, e_r1, e_err, e_rd);
        tg = tag_of(v.mode);
        @(negedge clk);
        cur_lat   = v.lat;
        instr_loc = v.loc; mode = v.mode; r1_in = v.r1; xr_in = v.xr;
        base      = rd_cnt;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v.mode == 4'd5 || v.mode > 4'd8)
            chk(tg, "done one cycle after start", {31'd0, done}, 32'd1);
        if (poke) begin
            @(negedge clk);
            // R13: second start and changed inputs during a run
            mode = 4'd5; r1_in = 16'h1111; xr_in = 16'h2222; instr_loc = 16'h3333;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(poke ? "R13" : tg, "done seen", {31'd0, done}, 32'd1);
        chk(tg, "ea",       {16'd0, ea},      {16'd0, e_ea});
        chk(tg, "operand",  {16'd0, operand}, {16'd0, e_op});
        chk(tg, "r1_out",   {16'd0, r1_out},  {16'd0, e_r1});
        chk(e_err ? "R12" : tg, "mode_err", {31'd0, mode_err}, {31'd0, e_err});
        chk(tg, "read count", rd_cnt - base, e_rd);
        if (v.mode <= 4'd4)
            chk("R2", "first read address", {16'd0, addr_log[base % 16]},
                {16'd0, v.loc + 16'd1});
        @(negedge clk);
        chk("R13", "done single cycle", {31'd0, done}, 32'd0);
        chk(tg, "r1_out held after done", {16'd0, r1_out}, {16'd0, e_r1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        chk("R1", "done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done",     {31'd0, done},     32'd0);
        chk("R1", "mem_req",  {31'd0, mem_req},  32'd0);
        chk("R1", "mode_err", {31'd0, mode_err}, 32'd0);
        chk("R1", "ea",       {16'd0, ea},       32'd0);
        chk("R1", "operand",  {16'd0, operand},  32'd0);
        chk("R1", "r1_out",   {16'd0, r1_out},   32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // directed: start pulsed while busy (R13), slow and fast memories
        run_vec(VECS[3], 1'b1);
        run_vec(VECS[0], 1'b1);
        // back-to-back autodecrement after an error
        run_vec(VECS[13], 1'b0);
        run_vec(VECS[11], 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule